// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration space of a single bus device. Software reaches it through a simple request port that carries a byte address, write data, a transfer size and a read/write flag. Reads return one, two or four bytes in little-endian order. Writes update one to four consecutive bytes, but only the bits that the per-byte write mask allows; every other bit keeps its previous value.

The write mask is fixed by the address. The identity bytes and most header fields are read-only. The cache-line and interrupt-line bytes are writable, as are three enable bits of the command byte and the device-specific area from 0x40 up. The six address-region dwords are writable through a parameterised mask. The identity values are parameters that are loaded at reset. When a write changes an address-region byte, or flips the I/O-decode or memory-decode enable, the block raises a one-cycle remap strobe so that the decoders around it can rebuild their windows.

Top module: `cfg_space`

## Requirements
- R1: After reset, bytes 0x00-0x03 hold IDENT_ID (byte 0x00 is bits 7:0), bytes 0x08-0x0B hold CLASS_REV in the same order, byte 0x0E holds HDR_TYPE, and every other byte is zero.
- R2: Each written byte becomes (old AND NOT mask) OR (new AND mask); bytes whose mask is zero (identity, class, header type, status 0x05-0x07) ignore writes.
- R3: Byte 0x0C (cache-line size) and byte 0x3C (interrupt line) have mask 0xFF.
- R4: Byte 0x04 (command) has mask 0x07: bit 0 is I/O decode enable, bit 1 is memory decode enable, bit 2 is bus-master enable.
- R5: Every byte from 0x40 through 0xFF has mask 0xFF.
- R6: Bytes 0x10-0x27 (six address-region dwords) take their mask from byte (addr-0x10) mod 4 of BAR_MASK.
- R7: A write of req_size bytes (1-4; 0 writes nothing; 5-7 act as 4) stores req_wdata[7:0] at req_addr, the next byte at req_addr+1 and so on, and drops any byte whose address would be 0x100 or above.
- R8: A read (req_size 4 = dword, 2 = word, any other = byte) places the little-endian value, zero-extended, on rd_data on the clock edge that accepts it; rd_data holds its value on cycles without a read.
- R9: A dword read at an address above 0xFC returns 0xFFFFFFFF; a word read at 0xFF returns 0x0000FFFF.
- R10: remap_pulse is high for exactly the one cycle after a write that changes any byte in 0x10-0x27 or toggles bit 0 or bit 1 of byte 0x04; it stays low for all other accesses, including writes that change only bit 2 or store an unchanged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Starting byte address |
| req_size | input | 3 | Number of bytes |
| req_wdata | input | 32 | Write data, lowest byte first |
| rd_data | output | 32 | Registered read result |
| remap_pulse | output | 1 | One-cycle remap request |

## Verification
The remap strobe is the hard case. Most header bytes are read-only, so a write only reaches the detector through the region or command lanes. A write that stores the same value, or that toggles only bus-master, must leave the strobe low. Directed writes repeat region values, flip bit 2 on its own, and place multi-byte writes so that they straddle 0x0F/0x10 and 0x27/0x28. A long seeded random run then compares every cycle against a byte-array model. Its addresses are weighted toward the header and the top of the space, so that truncation at 0xFF and wide reads past 0xFC also occur.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [31:0] IDENT_ID  = 32'h1234_ABCD,
  parameter logic [31:0] CLASS_REV = 32'h0200_0001,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [31:0] BAR_MASK  = 32'hFFFF_FFF0,
  parameter int          NBYTES    = 256,
  parameter int          LANES     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic [31:0] rd_data,
  output logic        remap_pulse
);
  localparam int AW = $clog2(NBYTES);

  logic [7:0] cfg [NBYTES];

  function automatic logic [7:0] wmask(input logic [AW-1:0] a);
    if (a == 8'h0C || a == 8'h3C || a >= 8'h40) return 8'hFF;
    if (a == 8'h04) return 8'h07;
    if (a >= 8'h10 && a <= 8'h27) return BAR_MASK[8*(a[1:0]) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] init_val(input int a);
    if (a < 4) return IDENT_ID[8*a +: 8];
    if (a >= 8 && a < 12) return CLASS_REV[8*(a-8) +: 8];
    if (a == 14) return HDR_TYPE;
    return 8'h00;
  endfunction

  logic             do_wr, do_rd;
  logic [LANES-1:0] lane_en;
  logic [AW-1:0]    lane_idx [LANES];
  logic [7:0]       lane_new [LANES];
  logic             remap_hit;
  logic [31:0]      rd_next;

  assign do_wr = req_valid && req_write;
  assign do_rd = req_valid && !req_write;

  always_comb begin
    remap_hit = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      logic [AW:0] sum;
      logic [7:0]  old;
      sum         = {1'b0, req_addr} + (AW+1)'(k);
      lane_idx[k] = sum[AW-1:0];
      lane_en[k]  = do_wr && (k < int'(req_size)) && !sum[AW];
      old         = cfg[lane_idx[k]];
      lane_new[k] = (old & ~wmask(lane_idx[k])) | (req_wdata[8*k +: 8] & wmask(lane_idx[k]));
      if (lane_en[k]) begin
        if (lane_idx[k] >= 8'h10 && lane_idx[k] <= 8'h27 && lane_new[k] != old) remap_hit = 1'b1;
        if (lane_idx[k] == 8'h04 && ((lane_new[k] ^ old) & 8'h03) != 8'h00) remap_hit = 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = 32'h0;
    if (req_size == 3'd4) begin
      if (req_addr <= 8'hFC)
        rd_next = {cfg[req_addr + 8'd3], cfg[req_addr + 8'd2], cfg[req_addr + 8'd1], cfg[req_addr]};
      else
        rd_next = 32'hFFFF_FFFF;
    end else if (req_size == 3'd2) begin
      if (req_addr <= 8'hFE) rd_next = {16'h0, cfg[req_addr + 8'd1], cfg[req_addr]};
      else                   rd_next = 32'h0000_FFFF;
    end else begin
      rd_next = {24'h0, cfg[req_addr]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cfg[i] <= init_val(i);
      rd_data     <= 32'h0;
      remap_pulse <= 1'b0;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (lane_en[k]) cfg[lane_idx[k]] <= lane_new[k];
      if (do_rd) rd_data <= rd_next;
      remap_pulse <= remap_hit;
    end
  end

  assert_ident_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({cfg[3], cfg[2], cfg[1], cfg[0]}));
  assert_status_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $stable({cfg[7], cfg[6], cfg[5]}));
  assert_cmd_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[4][7:3] == 5'h0);
  assert_remap_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remap_pulse) |-> $past(do_wr));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> $stable(rd_data));
  assert_dword_oob_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && req_size == 3'd4 && req_addr > 8'hFC) |=> rd_data == 32'hFFFF_FFFF);
endmodule

// File: tb/cfg_space_test.sv
module cfg_space_test;
  localparam logic [31:0] ID  = 32'h1234_ABCD;
  localparam logic [31:0] CR  = 32'h0200_0001;
  localparam logic [7:0]  HT  = 8'h00;
  localparam logic [31:0] BM  = 32'hFFFF_FFF0;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [2:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rd_data;
  logic        remap_pulse;

  cfg_space #(.IDENT_ID(ID), .CLASS_REV(CR), .HDR_TYPE(HT), .BAR_MASK(BM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_data), .remap_pulse(remap_pulse));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  logic [7:0]  m [256];
  logic [31:0] exp_rd = 0;
  logic        exp_remap = 0;
  bit          armed = 0;

  function automatic logic [7:0] mask_of(int a);
    if (a == 12 || a == 60 || a >= 64) return 8'hFF;
    if (a == 4) return 8'h07;
    if (a >= 16 && a <= 39) return BM[8*((a-16)%4) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] rst_of(int a);
    if (a < 4) return ID[8*a +: 8];
    if (a >= 8 && a < 12) return CR[8*(a-8) +: 8];
    if (a == 14) return HT;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m[i] = rst_of(i);
      exp_rd = 0; exp_remap = 0;
    end else begin
      exp_remap = 0;
      if (req_valid && req_write) begin
        int n;
        n = (req_size > 4) ? 4 : int'(req_size);
        for (int k = 0; k < n; k++) begin
          int a;
          logic [7:0] nv;
          a = int'(req_addr) + k;
          if (a < 256) begin
            nv = (m[a] & ~mask_of(a)) | (req_wdata[8*k +: 8] & mask_of(a));
            if (a >= 16 && a <= 39 && nv != m[a]) exp_remap = 1;
            if (a == 4 && ((nv ^ m[a]) & 8'h03) != 0) exp_remap = 1;
            m[a] = nv;
          end
        end
      end else if (req_valid) begin
        int a;
        a = int'(req_addr);
        if (req_size == 4)
          exp_rd = (a > 252) ? 32'hFFFF_FFFF : {m[a+3], m[a+2], m[a+1], m[a]};
        else if (req_size == 2)
          exp_rd = (a > 254) ? 32'h0000_FFFF : {16'h0, m[a+1], m[a]};
        else
          exp_rd = {24'h0, m[a]};
      end
      armed = 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (armed) begin
      checks++;
      if (rd_data !== exp_rd || remap_pulse !== exp_remap) begin
        fails++;
        $display("FAIL %s: rd_data=%h remap=%b expected rd_data=%h remap=%b",
                 tag, rd_data, remap_pulse, exp_rd, exp_remap);
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic op(bit w, logic [7:0] a, logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";  op(0, 8'h00, 4, 0); op(0, 8'h08, 4, 0); op(0, 8'h0E, 1, 0); op(0, 8'h30, 4, 0);
    tag = "R2";  op(1, 8'h00, 4, 32'hFFFF_FFFF); op(0, 8'h00, 4, 0);
                 op(1, 8'h05, 3, 32'hFFFFFF); op(0, 8'h04, 4, 0);
    tag = "R3";  op(1, 8'h0C, 1, 32'hA5); op(1, 8'h3C, 1, 32'h5A); op(0, 8'h0C, 1, 0); op(0, 8'h3C, 1, 0);
    tag = "R4";  op(1, 8'h04, 1, 32'hFF); op(0, 8'h04, 2, 0);
    tag = "R10"; op(1, 8'h04, 1, 32'hFF); op(1, 8'h04, 1, 32'h03); op(1, 8'h04, 1, 32'h01);
    tag = "R5";  op(1, 8'h40, 4, 32'hDEAD_BEEF); op(0, 8'h40, 4, 0); op(1, 8'h80, 2, 32'h1357); op(0, 8'h80, 2, 0);
    tag = "R6";  op(1, 8'h10, 4, 32'h1234_5678); op(0, 8'h10, 4, 0); op(1, 8'h10, 4, 32'h1234_5678);
                 op(1, 8'h0E, 4, 32'hFFFF_FFFF); op(1, 8'h26, 4, 32'hABCD_EF01); op(0, 8'h24, 4, 0);
    tag = "R7";  op(1, 8'hFE, 4, 32'h4433_2211); op(0, 8'hFC, 4, 0); op(1, 8'h50, 0, 32'hFF);
                 op(0, 8'h50, 1, 0); op(1, 8'h60, 7, 32'h0102_0304); op(0, 8'h60, 4, 0);
    tag = "R8";  op(0, 8'h61, 2, 0); op(0, 8'h62, 3, 0); repeat (3) @(negedge clk);
    tag = "R9";  op(0, 8'hFD, 4, 0); op(0, 8'hFF, 2, 0); op(0, 8'hFE, 2, 0); op(0, 8'hFC, 4, 0);
    tag = "R7";
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [2:0] s;
      case ($urandom % 3)
        0: a = 8'($urandom % 48);
        1: a = 8'hF8 + 8'($urandom % 8);
        default: a = 8'($urandom);
      endcase
      s = 3'($urandom);
      op(1'($urandom), a, s, $urandom);
    end
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule